// File: doc/BRIEF.md
# Snooping MESI Line-State Controller

This block keeps the coherence state of a small set of cache lines for one private cache on a shared snooping bus. Each line is Invalid, Shared, Exclusive or Modified. A processor read or write, qualified by a line index, produces a hit indication and, when needed, a bus request: a bus read to get a readable copy or a read-exclusive to get a writable one. Bus operations from other caches arrive on the snoop port. The controller answers them by driving its contribution to a wired-OR shared line and by raising a flush strobe when it holds the only up-to-date copy. It then downgrades or invalidates its own copy.

The Exclusive state is what sets this controller apart from a three-state scheme. A read miss samples the shared line in the same cycle as its bus read. If no other cache claims a copy, the line is held Exclusive, and a later write upgrades it to Modified without any bus traffic. Bus transactions complete in the cycle they are issued. The surrounding bus model lets at most one cache issue a bus request per cycle and forwards it to every other cache as a snoop. Data storage, replacement, memory timing and arbitration live outside the block.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, so `cpuHit` is low for every index.
- R2: A read to an Invalid line drives `busReqValid` with `busReqKind` = 2'b01 (bus read). The line becomes Exclusive when `sharedIn` is low in that cycle and Shared when it is high. Exclusive shows up as a later silent write; Shared shows up as a later write that needs the bus.
- R3: A write to an Invalid or Shared line drives `busReqValid` with `busReqKind` = 2'b10 (read-exclusive), and the line becomes Modified.
- R4: A write to an Exclusive line moves it to Modified with `busReqValid` low.
- R5: Reads to Shared, Exclusive or Modified lines and writes to Modified lines leave `busReqValid` low (`busReqKind` = 2'b00) and leave the line state unchanged.
- R6: A snooped bus read (`snoopKind` = 2'b01) on a Modified line raises `flushOut` in that cycle and leaves the line Shared.
- R7: A snooped bus read on an Exclusive line leaves it Shared. On a Shared line it stays Shared. Neither raises `flushOut`.
- R8: A snooped read-exclusive (`snoopKind` = 2'b10) on any valid line leaves it Invalid, and raises `flushOut` in that cycle only if the line was Modified.
- R9: `sharedOut` is high exactly when a snooped bus read targets a line held valid.
- R10: When a snoop and a processor request name the same index in the same cycle, `cpuStall` is high, the snoop update is applied, and the processor request changes no state.
- R11: `cpuHit` reports, combinationally, whether the line at `cpuReqIdx` is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReqValid | input | 1 | Processor request present |
| cpuReqWrite | input | 1 | 1 = write, 0 = read |
| cpuReqIdx | input | IDX_W | Line index of the processor request |
| cpuHit | output | 1 | Line at cpuReqIdx is valid |
| cpuStall | output | 1 | Request lost to a same-line snoop; retry next cycle |
| busReqValid | output | 1 | Bus transaction issued this cycle |
| busReqKind | output | 2 | 00 none, 01 bus read, 10 read-exclusive |
| busReqIdx | output | IDX_W | Line index of the bus transaction |
| snoopValid | input | 1 | Another cache's bus transaction is visible |
| snoopKind | input | 2 | 01 bus read, 10 read-exclusive |
| snoopIdx | input | IDX_W | Line index of the snooped transaction |
| sharedIn | input | 1 | Wired-OR shared line seen by this cache's bus read |
| sharedOut | output | 1 | This cache's contribution to the shared line |
| flushOut | output | 1 | This cache supplies the dirty line for the snooped request |

## Verification
The bench builds two controllers with eight lines each and cross-couples them as one bus. It adds a third, bench-driven bus master that holds no lines, so a bus read can land on a line that is already Shared in both caches. With two live caches the bench reaches the Modified-to-Shared flush, invalidation of a dirty peer, and a snoop colliding with a local hit on the same line. The eight-line depth lets one test touch the first and last index and keep other lines in unrelated states.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [1:0] {
    LS_INV = 2'b00,
    LS_SHR = 2'b01,
    LS_EXC = 2'b10,
    LS_MOD = 2'b11
  } lineState_t;

  typedef enum logic [1:0] {
    BUS_NONE = 2'b00,
    BUS_RD   = 2'b01,
    BUS_RDX  = 2'b10
  } busOp_t;

  // strobes from control to the state store
  typedef struct packed {
    logic       snpWe;
    lineState_t snpNext;
    logic       cpuWe;
    lineState_t cpuNext;
  } stateStrobe_t;

endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
  import mesi_pkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  stateStrobe_t stb,
  input  logic [IDX_W-1:0] cpuIdx,
  input  logic [IDX_W-1:0] snpIdx,
  output lineState_t   cpuLineState,
  output lineState_t   snpLineState,
  output logic         idxMatch
);

  lineState_t lineState [NUM_LINES];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rstN) begin
        lineState[g] <= LS_INV;
      end else if (stb.snpWe && (snpIdx == IDX_W'(g))) begin
        lineState[g] <= stb.snpNext;
      end else if (stb.cpuWe && (cpuIdx == IDX_W'(g))) begin
        lineState[g] <= stb.cpuNext;
      end
    end
  end

  assign cpuLineState = lineState[cpuIdx];
  assign snpLineState = lineState[snpIdx];
  assign idxMatch     = (cpuIdx == snpIdx);

endmodule

// File: rtl/mesi_ctrl_logic.sv
module mesi_ctrl_logic
  import mesi_pkg::*;
(
  input  logic         cpuReqValid,
  input  logic         cpuReqWrite,
  input  lineState_t   cpuLineState,
  input  logic         snoopValid,
  input  logic [1:0]   snoopKind,
  input  lineState_t   snpLineState,
  input  logic         idxMatch,
  input  logic         sharedIn,
  output stateStrobe_t stb,
  output logic         cpuHit,
  output logic         cpuStall,
  output logic         busReqValid,
  output logic [1:0]   busReqKind,
  output logic         sharedOut,
  output logic         flushOut
);

  busOp_t     snpOp;
  busOp_t     reqOp;
  logic       cpuWe;
  lineState_t cpuNext;
  logic       snpWe;
  lineState_t snpNext;
  logic       snpHeld;

  assign snpOp = busOp_t'(snoopKind);

  // processor side
  always_comb begin
    cpuHit   = (cpuLineState != LS_INV);
    cpuStall = cpuReqValid && snoopValid && idxMatch;
    reqOp    = BUS_NONE;
    cpuWe    = 1'b0;
    cpuNext  = cpuLineState;
    if (cpuReqValid) begin
      if (!cpuReqWrite) begin
        if (cpuLineState == LS_INV) begin
          reqOp   = BUS_RD;
          cpuWe   = 1'b1;
          cpuNext = sharedIn ? LS_SHR : LS_EXC;
        end
      end else begin
        unique case (cpuLineState)
          LS_INV, LS_SHR: begin
            reqOp   = BUS_RDX;
            cpuWe   = 1'b1;
            cpuNext = LS_MOD;
          end
          LS_EXC: begin
            cpuWe   = 1'b1;
            cpuNext = LS_MOD;
          end
          default: ;
        endcase
      end
      if (cpuStall) cpuWe = 1'b0;
    end
  end

  assign busReqValid = (reqOp != BUS_NONE);
  assign busReqKind  = reqOp;

  // snoop side
  always_comb begin
    snpHeld   = snoopValid && (snpLineState != LS_INV);
    sharedOut = snpHeld && (snpOp == BUS_RD);
    flushOut  = snoopValid && (snpLineState == LS_MOD) &&
                ((snpOp == BUS_RD) || (snpOp == BUS_RDX));
    snpWe     = snpHeld && ((snpOp == BUS_RD) || (snpOp == BUS_RDX));
    snpNext   = (snpOp == BUS_RDX) ? LS_INV : LS_SHR;
  end

  assign stb = '{snpWe: snpWe, snpNext: snpNext, cpuWe: cpuWe, cpuNext: cpuNext};

endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
  import mesi_pkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpuReqValid,
  input  logic             cpuReqWrite,
  input  logic [IDX_W-1:0] cpuReqIdx,
  output logic             cpuHit,
  output logic             cpuStall,
  output logic             busReqValid,
  output logic [1:0]       busReqKind,
  output logic [IDX_W-1:0] busReqIdx,
  input  logic             snoopValid,
  input  logic [1:0]       snoopKind,
  input  logic [IDX_W-1:0] snoopIdx,
  input  logic             sharedIn,
  output logic             sharedOut,
  output logic             flushOut
);

  stateStrobe_t stb;
  lineState_t   cpuLineState;
  lineState_t   snpLineState;
  logic         idxMatch;

  mesi_line_store #(.NUM_LINES(NUM_LINES)) u_store (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .cpuIdx       (cpuReqIdx),
    .snpIdx       (snoopIdx),
    .cpuLineState (cpuLineState),
    .snpLineState (snpLineState),
    .idxMatch     (idxMatch)
  );

  mesi_ctrl_logic u_ctrl (
    .cpuReqValid  (cpuReqValid),
    .cpuReqWrite  (cpuReqWrite),
    .cpuLineState (cpuLineState),
    .snoopValid   (snoopValid),
    .snoopKind    (snoopKind),
    .snpLineState (snpLineState),
    .idxMatch     (idxMatch),
    .sharedIn     (sharedIn),
    .stb          (stb),
    .cpuHit       (cpuHit),
    .cpuStall     (cpuStall),
    .busReqValid  (busReqValid),
    .busReqKind   (busReqKind),
    .sharedOut    (sharedOut),
    .flushOut     (flushOut)
  );

  assign busReqIdx = cpuReqIdx;

endmodule

// File: rtl/mesi_snoop_ctrl_chk.sv
module mesi_snoop_ctrl_chk #(
  parameter int NUM_LINES = 8,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             cpuReqValid,
  input logic             cpuReqWrite,
  input logic [IDX_W-1:0] cpuReqIdx,
  input logic             cpuHit,
  input logic             cpuStall,
  input logic             busReqValid,
  input logic             snoopValid,
  input logic [1:0]       snoopKind,
  input logic [IDX_W-1:0] snoopIdx,
  input logic             sharedOut,
  input logic             flushOut
);

  AST_STALL_ON_COLLISION: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReqValid && snoopValid && (cpuReqIdx == snoopIdx)) |-> cpuStall); // R10

  AST_READ_HIT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReqValid && !cpuReqWrite && cpuHit) |-> !busReqValid); // R5

  AST_SNOOPED_RDX_KILLS: assert property (@(posedge clk) disable iff (!rstN)
    (snoopValid && (snoopKind == 2'b10)) ##1
    (cpuReqValid && (cpuReqIdx == $past(snoopIdx))) |-> !cpuHit); // R8

  AST_WRITE_LEAVES_OWNER: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReqValid && cpuReqWrite && !cpuStall) ##1
    (cpuReqValid && cpuReqWrite && !snoopValid && (cpuReqIdx == $past(cpuReqIdx)))
    |-> (cpuHit && !busReqValid)); // R3

  AST_SHARED_NEEDS_READ: assert property (@(posedge clk) disable iff (!rstN)
    sharedOut |-> (snoopValid && (snoopKind == 2'b01))); // R9

  AST_FLUSH_NEEDS_SNOOP: assert property (@(posedge clk) disable iff (!rstN)
    flushOut |-> snoopValid); // R6

endmodule

bind mesi_snoop_ctrl mesi_snoop_ctrl_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cpuReqValid (cpuReqValid),
  .cpuReqWrite (cpuReqWrite),
  .cpuReqIdx   (cpuReqIdx),
  .cpuHit      (cpuHit),
  .cpuStall    (cpuStall),
  .busReqValid (busReqValid),
  .snoopValid  (snoopValid),
  .snoopKind   (snoopKind),
  .snoopIdx    (snoopIdx),
  .sharedOut   (sharedOut),
  .flushOut    (flushOut)
);

// File: tb/mesi_snoop_ctrl_tb.sv
`timescale 1ns/1ps
module mesi_snoop_ctrl_tb;

  localparam int N  = 8;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0]    cv, cw;
  logic [IW-1:0] ci0, ci1;
  logic [1:0]    hit, stall, bv, shOut, fl;
  logic [1:0]    bk0, bk1;
  logic [IW-1:0] bi0, bi1;
  logic          xv;
  logic [1:0]    xk;
  logic [IW-1:0] xi;

  // modelled bus: peer request or bench master, seen by the other cache
  logic          sv0, sv1;
  logic [1:0]    sk0, sk1;
  logic [IW-1:0] si0, si1;
  assign sv0 = bv[1] | xv;
  assign sk0 = bv[1] ? bk1 : xk;
  assign si0 = bv[1] ? bi1 : xi;
  assign sv1 = bv[0] | xv;
  assign sk1 = bv[0] ? bk0 : xk;
  assign si1 = bv[0] ? bi0 : xi;

  mesi_snoop_ctrl #(.NUM_LINES(N)) u_dut (
    .clk(clk), .rstN(rstN),
    .cpuReqValid(cv[0]), .cpuReqWrite(cw[0]), .cpuReqIdx(ci0),
    .cpuHit(hit[0]), .cpuStall(stall[0]),
    .busReqValid(bv[0]), .busReqKind(bk0), .busReqIdx(bi0),
    .snoopValid(sv0), .snoopKind(sk0), .snoopIdx(si0),
    .sharedIn(shOut[1]), .sharedOut(shOut[0]), .flushOut(fl[0])
  );

  mesi_snoop_ctrl #(.NUM_LINES(N)) u_peer (
    .clk(clk), .rstN(rstN),
    .cpuReqValid(cv[1]), .cpuReqWrite(cw[1]), .cpuReqIdx(ci1),
    .cpuHit(hit[1]), .cpuStall(stall[1]),
    .busReqValid(bv[1]), .busReqKind(bk1), .busReqIdx(bi1),
    .snoopValid(sv1), .snoopKind(sk1), .snoopIdx(si1),
    .sharedIn(shOut[0]), .sharedOut(shOut[1]), .flushOut(fl[1])
  );

  typedef struct {
    logic [6:0] exp0;
    logic [6:0] exp1;
    string      tag;
  } expItem_t;

  expItem_t q[$];
  event     go;
  int       nRun  = 0;
  int       nFail = 0;
  bit       done  = 0;
  int       st [2][N];   // 0 I, 1 S, 2 E, 3 M

  // driver: compute expectation from the rules, push it, apply stimulus
  task automatic step(input logic v0, input logic w0, input int i0,
                      input logic v1, input logic w1, input int i1,
                      input logic ev, input logic [1:0] ek, input int ei,
                      input string tag);
    logic v[2], w[2], need[2], req[2], snV[2], sh[2], fls[2], stl[2];
    int   idx[2], knd[2], snK[2], snI[2], nx[2][N];
    expItem_t it;
    v[0] = v0; w[0] = w0; idx[0] = i0;
    v[1] = v1; w[1] = w1; idx[1] = i1;
    for (int c = 0; c < 2; c++) begin
      int s = st[c][idx[c]];
      need[c] = !w[c] ? (s == 0) : (s <= 1);
      req[c]  = v[c] && need[c];
      knd[c]  = req[c] ? (w[c] ? 2 : 1) : 0;
    end
    for (int c = 0; c < 2; c++) begin
      int o = 1 - c;
      snV[c] = req[o] || ev;
      snK[c] = req[o] ? knd[o] : int'(ek);
      snI[c] = req[o] ? idx[o] : ei;
      sh[c]  = snV[c] && (snK[c] == 1) && (st[c][snI[c]] != 0);
      fls[c] = snV[c] && (st[c][snI[c]] == 3);
      stl[c] = v[c] && snV[c] && (snI[c] == idx[c]);
    end
    for (int c = 0; c < 2; c++) begin
      for (int k = 0; k < N; k++) nx[c][k] = st[c][k];
      if (snV[c] && st[c][snI[c]] != 0) nx[c][snI[c]] = (snK[c] == 2) ? 0 : 1;
      if (v[c] && !stl[c]) begin
        if (w[c]) nx[c][idx[c]] = 3;
        else if (st[c][idx[c]] == 0) nx[c][idx[c]] = sh[1-c] ? 1 : 2;
      end
    end
    it.exp0 = {st[0][idx[0]] != 0, stl[0], req[0], 2'(knd[0]), sh[0], fls[0]};
    it.exp1 = {st[1][idx[1]] != 0, stl[1], req[1], 2'(knd[1]), sh[1], fls[1]};
    it.tag  = tag;
    for (int c = 0; c < 2; c++)
      for (int k = 0; k < N; k++) st[c][k] = nx[c][k];
    @(negedge clk);
    cv[0] = v0; cw[0] = w0; ci0 = IW'(i0);
    cv[1] = v1; cw[1] = w1; ci1 = IW'(i1);
    xv = ev; xk = ek; xi = IW'(ei);
    q.push_back(it);
    ->go;
  endtask

  // monitor: pop and compare while outputs are settled, before the edge
  initial begin
    forever begin
      expItem_t it;
      logic [6:0] act0, act1;
      @(go);
      #1;
      it = q.pop_front();
      act0 = {hit[0], stall[0], bv[0], bk0, shOut[0], fl[0]};
      act1 = {hit[1], stall[1], bv[1], bk1, shOut[1], fl[1]};
      nRun += 2;
      if (act0 !== it.exp0) begin
        nFail++;
        $display("FAIL %s cache0 {hit,stall,bus,kind,shared,flush} actual=%b expected=%b",
                 it.tag, act0, it.exp0);
      end
      if (act1 !== it.exp1) begin
        nFail++;
        $display("FAIL %s cache1 {hit,stall,bus,kind,shared,flush} actual=%b expected=%b",
                 it.tag, act1, it.exp1);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      nFail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 2; c++)
      for (int k = 0; k < N; k++) st[c][k] = 0;
    cv = '0; cw = '0; ci0 = '0; ci1 = '0; xv = 0; xk = 2'b00; xi = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R1 / R11: empty after reset, first and last index
    step(0,0,0, 0,0,0, 0,2'b00,0, "R1_first");
    step(0,0,N-1, 0,0,N-1, 0,2'b00,0, "R1_last");
    // R2: lone read miss -> Exclusive
    step(1,0,2, 0,0,0, 0,2'b00,0, "R2_rd_miss_excl");
    // R4: silent Exclusive -> Modified
    step(1,1,2, 0,0,0, 0,2'b00,0, "R4_silent_upgrade");
    // R5: hits in Modified
    step(1,1,2, 0,0,0, 0,2'b00,0, "R5_wr_hit_mod");
    step(1,0,2, 0,0,0, 0,2'b00,0, "R5_rd_hit_mod");
    // R6 / R9 / R2: peer read on Modified -> flush, both Shared
    step(0,0,0, 1,0,2, 0,2'b00,0, "R6_R9_flush_on_read");
    step(1,0,2, 1,0,2, 0,2'b00,0, "R5_rd_hit_shared");
    // R3 / R8: write to Shared -> read-exclusive, peer copy dropped
    step(0,0,0, 1,1,2, 0,2'b00,0, "R3_R8_wr_shared");
    step(1,0,2, 0,0,0, 0,2'b00,0, "R8_reread_after_inval");
    // R7: snooped read on Exclusive -> Shared, no flush
    step(1,0,5, 0,0,0, 0,2'b00,0, "R2_rd_miss_5");
    step(0,0,0, 1,0,5, 0,2'b00,0, "R7_excl_to_shared");
    step(1,1,5, 0,0,0, 0,2'b00,0, "R2_shared_write_needs_bus");
    step(0,0,0, 1,0,5, 0,2'b00,0, "R6_refetch_5");
    // R7 / R9: bench master reads a line Shared in both caches
    step(0,0,5, 0,0,5, 1,2'b01,5, "R7_R9_shared_stays");
    step(1,0,5, 1,0,5, 0,2'b00,0, "R7_still_valid");
    step(0,0,3, 0,0,3, 1,2'b01,3, "R9_no_share_invalid");
    // R3 / R8: write miss, then dirty peer invalidated with flush
    step(1,1,6, 0,0,0, 0,2'b00,0, "R3_wr_miss");
    step(0,0,0, 1,1,6, 0,2'b00,0, "R8_flush_on_rdx");
    // R10: snoop collides with a local hit on the same line
    step(1,0,5, 1,1,5, 0,2'b00,0, "R10_stall_collision");
    step(1,0,5, 0,0,0, 0,2'b00,0, "R10_retry_after_stall");
    // R8: read-exclusive on Exclusive line, no flush
    step(1,0,4, 0,0,0, 0,2'b00,0, "R2_rd_miss_4");
    step(0,0,4, 0,0,0, 1,2'b10,4, "R8_excl_killed");
    step(1,0,4, 0,0,0, 0,2'b00,0, "R8_miss_again");
    step(0,0,0, 0,0,0, 0,2'b00,0, "idle");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule